// File: doc/BRIEF.md
# Multi-Channel Border Padding Stream

This block sits in front of a sliding-window convolution engine. It takes a feature map as a valid/ready stream of 64-bit words and emits the same map with a frame of constant pixels around it. Each word carries eight 8-bit channel lanes of one pixel. A pixel with more than eight channels spans several consecutive words, one per group of eight channels. Pixels arrive in row-major order.

A one-cycle start pulse captures the frame description: padding enable, channel count, row count, column count, border thickness and fill byte. After that the block walks the padded output grid. It counts channel groups, then columns, then rows. Border positions are generated locally from the fill byte. Interior positions are taken from the input stream one word at a time and passed on unchanged. There is no buffering: an interior word is consumed in the same cycle that the consumer accepts it. The block never stores the image.

Top module: `borderPadStream`

## Requirements
- R1: After reset, and until a start pulse is accepted, `outValid` and `inReady` are both low.
- R2: With padding enabled and thickness z, one frame produces (rows+2z)×(cols+2z) pixels in row-major order. Each pixel is chanCount/8 consecutive words. Exactly rows×cols×chanCount/8 input words are consumed.
- R3: Every word of a border pixel has the fill byte in all eight lanes. Lane k occupies bits [8k+7:8k].
- R4: Interior words leave in input order and are bit-for-bit equal to the input word. Lane order is kept: channel 0 of the group stays in bits [7:0].
- R5: With padding disabled, the thickness input is ignored. The output is the input stream unchanged, with the input dimensions.
- R6: `inReady` is high only when an interior word is due and `outReady` is high. It stays low while a border word is due.
- R7: The start pulse captures all runtime inputs. A start pulse during an active frame has no effect. Input changes after the start pulse also have no effect on the frame in progress.
- R8: After the last word of a frame is accepted, the block is idle until the next start: `outValid` and `inReady` are low and input words are not taken. With padding enabled and z = 0, the output equals the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse; captures the runtime inputs |
| padEn | input | 1 | Enable the border |
| chanCount | input | 10 | Channels per pixel, a nonzero multiple of 8 |
| rowCount | input | 11 | Input rows, nonzero |
| colCount | input | 11 | Input columns, nonzero |
| borderWidth | input | 3 | Border thickness in pixels |
| fillByte | input | 8 | Value placed in every lane of border pixels |
| inValid | input | 1 | Input word valid |
| inData | input | 64 | Input word, channel 0 of the group in the low byte |
| inReady | output | 1 | Input word taken this cycle when inValid is high |
| outValid | output | 1 | Output word valid |
| outData | output | 64 | Output word |
| outReady | input | 1 | Consumer accepts the output word |

## Verification
The properties assume that the source and the consumer follow ordinary valid/ready rules. They also assume that the start pulse comes with a legal description: a nonzero channel count that is a multiple of eight, and nonzero row and column counts. Under these assumptions, a word due for the border can be checked against the captured fill byte, and a taken input word can be checked against the emitted word. The bench draws its channel counts only from multiples of eight and its dimensions only from small nonzero values. Its source holds each word until the word is taken. Backpressure and source gaps are randomised from a fixed seed, so border and interior positions are hit under both stall patterns.

// File: rtl/borderPadPkg.sv
package borderPadPkg;
  // strobes from the walker to the datapath
  typedef struct packed {
    logic latch;    // capture frame description this cycle
    logic selFill;  // the word now due belongs to the border
  } padStrobe_t;
endpackage

// File: rtl/borderPadCtrl.sv
module borderPadCtrl
  import borderPadPkg::*;
#(
  parameter int LANES = 8,
  parameter int CH_W  = 10,
  parameter int DIM_W = 11,
  parameter int PAD_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             padEn,
  input  logic [CH_W-1:0]  chanCount,
  input  logic [DIM_W-1:0] rowCount,
  input  logic [DIM_W-1:0] colCount,
  input  logic [PAD_W-1:0] borderWidth,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output padStrobe_t       strobes,
  output logic             frameActive
);
  localparam int LANE_SH = $clog2(LANES);
  localparam int CNT_W   = DIM_W + 1;

  logic             activeQ;
  logic [CH_W-1:0]  grpQ, grpLastQ;
  logic [CNT_W-1:0] colQ, rowQ;
  logic [CNT_W-1:0] zQ, rowEndQ, colEndQ, rowLastQ, colLastQ;

  logic [CNT_W-1:0] zNext, rowEndNext, colEndNext;
  logic [CH_W-1:0]  grpCount;
  logic             interior, fire, accept;

  assign accept     = start && !activeQ;
  assign zNext      = padEn ? CNT_W'(borderWidth) : '0;
  assign rowEndNext = CNT_W'(rowCount) + zNext;
  assign colEndNext = CNT_W'(colCount) + zNext;
  assign grpCount   = chanCount >> LANE_SH;

  assign interior = (rowQ >= zQ) && (rowQ < rowEndQ) &&
                    (colQ >= zQ) && (colQ < colEndQ);

  assign outValid = activeQ && (!interior || inValid);
  assign inReady  = activeQ && interior && outReady;
  assign fire     = outValid && outReady;

  assign strobes.latch   = accept;
  assign strobes.selFill = !interior;
  assign frameActive     = activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      grpQ     <= '0;
      colQ     <= '0;
      rowQ     <= '0;
      grpLastQ <= '0;
      zQ       <= '0;
      rowEndQ  <= '0;
      colEndQ  <= '0;
      rowLastQ <= '0;
      colLastQ <= '0;
    end else if (accept) begin
      activeQ  <= 1'b1;
      grpQ     <= '0;
      colQ     <= '0;
      rowQ     <= '0;
      grpLastQ <= grpCount - CH_W'(1);
      zQ       <= zNext;
      rowEndQ  <= rowEndNext;
      colEndQ  <= colEndNext;
      rowLastQ <= rowEndNext + zNext - CNT_W'(1);
      colLastQ <= colEndNext + zNext - CNT_W'(1);
    end else if (fire) begin
      if (grpQ == grpLastQ) begin
        grpQ <= '0;
        if (colQ == colLastQ) begin
          colQ <= '0;
          if (rowQ == rowLastQ) begin
            rowQ    <= '0;
            activeQ <= 1'b0;
          end else begin
            rowQ <= rowQ + CNT_W'(1);
          end
        end else begin
          colQ <= colQ + CNT_W'(1);
        end
      end else begin
        grpQ <= grpQ + CH_W'(1);
      end
    end
  end
endmodule

// File: rtl/borderPadData.sv
module borderPadData
  import borderPadPkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  padStrobe_t              strobes,
  input  logic [LANE_W-1:0]       fillByte,
  input  logic [LANE_W*LANES-1:0] inData,
  output logic [LANE_W*LANES-1:0] outData,
  output logic [LANE_W-1:0]       fillQ
);
  logic [LANE_W*LANES-1:0] fillWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              fillQ <= '0;
    else if (strobes.latch) fillQ <= fillByte;
  end

  for (genvar k = 0; k < LANES; k++) begin : gLane
    assign fillWord[k*LANE_W +: LANE_W] = fillQ;
  end

  assign outData = strobes.selFill ? fillWord : inData;
endmodule

// File: rtl/borderPadStream.sv
module borderPadStream
  import borderPadPkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 8,
  parameter int CH_W   = 10,
  parameter int DIM_W  = 11,
  parameter int PAD_W  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    padEn,
  input  logic [CH_W-1:0]         chanCount,
  input  logic [DIM_W-1:0]        rowCount,
  input  logic [DIM_W-1:0]        colCount,
  input  logic [PAD_W-1:0]        borderWidth,
  input  logic [LANE_W-1:0]       fillByte,
  input  logic                    inValid,
  input  logic [LANE_W*LANES-1:0] inData,
  output logic                    inReady,
  output logic                    outValid,
  output logic [LANE_W*LANES-1:0] outData,
  input  logic                    outReady
);
  padStrobe_t        strobes;
  logic              frameActive;
  logic [LANE_W-1:0] fillQ;

  borderPadCtrl #(
    .LANES(LANES), .CH_W(CH_W), .DIM_W(DIM_W), .PAD_W(PAD_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .padEn(padEn),
    .chanCount(chanCount), .rowCount(rowCount), .colCount(colCount),
    .borderWidth(borderWidth), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobes(strobes),
    .frameActive(frameActive)
  );

  borderPadData #(
    .LANE_W(LANE_W), .LANES(LANES)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fillByte(fillByte),
    .inData(inData), .outData(outData), .fillQ(fillQ)
  );
endmodule

// File: rtl/borderPadChk.sv
module borderPadChk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inReady,
  input logic [LANE_W*LANES-1:0] inData,
  input logic                    outValid,
  input logic                    outReady,
  input logic [LANE_W*LANES-1:0] outData,
  input logic                    frameActive,
  input logic [LANE_W-1:0]       fillQ
);
  // R6
  take_needs_sink_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> outReady);

  // R1 R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> (!outValid && !inReady));

  // R3
  border_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inReady) |-> (outData == {LANES{fillQ}}));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (outValid && outData == inData));

  // R7
  active_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && !(outValid && outReady)) |=> frameActive);
endmodule

bind borderPadStream borderPadChk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inData(inData), .outValid(outValid), .outReady(outReady),
  .outData(outData), .frameActive(frameActive), .fillQ(fillQ)
);

// File: tb/borderPadStream_tb.sv
module borderPadStream_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        padEn = 1'b0;
  logic [9:0]  chanCount = '0;
  logic [10:0] rowCount = '0;
  logic [10:0] colCount = '0;
  logic [2:0]  borderWidth = '0;
  logic [7:0]  fillByte = '0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic        inReady;
  logic        outValid;
  logic [63:0] outData;
  logic        outReady = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  borderPadStream dut_i (
    .clk(clk), .rstN(rstN), .start(start), .padEn(padEn),
    .chanCount(chanCount), .rowCount(rowCount), .colCount(colCount),
    .borderWidth(borderWidth), .fillByte(fillByte), .inValid(inValid),
    .inData(inData), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outReady(outReady)
  );

  function automatic logic [63:0] srcWord(int k);
    logic [31:0] a, b;
    a = 32'(k) * 32'h9E37_79B1;
    b = 32'(k) ^ 32'h5A5A_0000;
    return {a, b};
  endfunction

  // expected word number idx of a frame; isBorder tells the kind
  function automatic logic [63:0] expWord(int idx, bit en, int ch, int rows,
      int cols, int z, logic [7:0] fill, output bit isBorder);
    int gpp, zz, oc, g, pix, r, c;
    gpp = ch / 8;
    zz  = en ? z : 0;
    oc  = cols + 2 * zz;
    g   = idx % gpp;
    pix = idx / gpp;
    r   = pix / oc;
    c   = pix % oc;
    isBorder = !(r >= zz && r < zz + rows && c >= zz && c < zz + cols);
    if (isBorder) return {8{fill}};
    return srcWord(((r - zz) * cols + (c - zz)) * gpp + g);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runFrame(bit en, int ch, int rows, int cols, int z,
      logic [7:0] fill, bit midRestart);
    int zz, nIn, nOut, inIdx, outIdx, cyc;
    bit takeQ, didRestart, r6Bad, isB;
    logic [63:0] e;
    zz   = en ? z : 0;
    nIn  = rows * cols * (ch / 8);
    nOut = (rows + 2 * zz) * (cols + 2 * zz) * (ch / 8);
    inIdx = 0; outIdx = 0; cyc = 0;
    takeQ = 0; didRestart = 0; r6Bad = 0;
    @(negedge clk);
    padEn = en; chanCount = 10'(ch); rowCount = 11'(rows);
    colCount = 11'(cols); borderWidth = 3'(z); fillByte = fill;
    inValid = 1'b0; start = 1'b1;
    while (outIdx < nOut && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (takeQ) begin inValid = 1'b0; takeQ = 0; end
      outReady = ($urandom % 4) != 0;
      if (!inValid && inIdx < nIn && ($urandom % 3) != 0) begin
        inValid = 1'b1;
        inData  = srcWord(inIdx);
      end
      if (midRestart && !didRestart && outIdx >= 5) begin
        // R7: restart with other values mid-frame must be ignored
        start = 1'b1; rowCount = 11'(rows + 4); fillByte = ~fill;
        padEn = !en; chanCount = 10'(ch + 8);
        didRestart = 1;
      end
      #1;
      e = expWord(outIdx, en, ch, rows, cols, z, fill, isB);
      if (inReady && (!outReady || isB)) r6Bad = 1;
      if (outValid && outReady) begin
        if (!en)      check(outData == e, "R5 word", outData, e);
        else if (isB) check(outData == e, "R3 border word", outData, e);
        else          check(outData == e, "R4 interior word", outData, e);
        outIdx++;
      end
      if (inValid && inReady) begin
        inIdx++;
        takeQ = 1;
      end
    end
    check(cyc < 5000, "R2 frame finished in time", 64'(outIdx), 64'(nOut));
    check(inIdx == nIn, "R2 input words consumed", 64'(inIdx), 64'(nIn));
    check(!r6Bad, "R6 ready only for interior with sink ready", 64'(r6Bad), 64'd0);
    // R8: idle after frame, offered input is not taken
    @(negedge clk);
    start = 1'b0;
    inValid = 1'b1; inData = 64'hDEAD_BEEF_0BAD_F00D; outReady = 1'b1;
    @(negedge clk);
    #1;
    check(!outValid && !inReady, "R8 idle after frame",
          {62'd0, outValid, inReady}, 64'd0);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #900us;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!outValid && !inReady, "R1 reset quiet", {62'd0, outValid, inReady}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    inValid = 1'b1; outReady = 1'b1;
    #1;
    check(!outValid && !inReady, "R1 quiet before start",
          {62'd0, outValid, inReady}, 64'd0);
    inValid = 1'b0;

    runFrame(1'b1, 16, 3, 4, 2, 8'hA5, 1'b1);   // R2 R3 R4 R7
    runFrame(1'b0, 8,  2, 5, 3, 8'h11, 1'b0);   // R5
    runFrame(1'b1, 8,  2, 2, 0, 8'h77, 1'b0);   // R8 z=0
    runFrame(1'b1, 24, 1, 1, 3, 8'h3C, 1'b0);   // single pixel, thick border
    runFrame(1'b1, 64, 2, 2, 1, 8'h00, 1'b0);   // eight words per pixel
    for (int i = 0; i < 8; i++) begin
      runFrame(1'($urandom % 4 != 0), 8 * (1 + int'($urandom % 4)),
               1 + int'($urandom % 5), 1 + int'($urandom % 5),
               int'($urandom % 4), 8'($urandom), 1'($urandom % 2));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule